// File: doc/BRIEF.md
# Microsequencer Run Control and Code Store

This block holds the instruction memory and program counter of a small context-switch microsequencer, and decides whether that sequencer is stopped, running or paused. A host reaches it through a narrow register port. Through that port the host loads code, moves the program counter, and issues start, pause and resume requests through a control register. It can also read back a status word and the instruction that is queued for execution.

A downstream decoder receives the queued instruction word and a run enable. The decoder pulses `advance_i` when it has consumed the word. It also raises `halt_i` or `end_i` when a halt or end instruction executes. Writing start and resume together does not change the run state. It only refetches the instruction at the current program counter. Together with a host write of the program counter, this lets the host read the whole code store back one word at a time.

Top module: `useq_run_ctrl`

## Requirements
- R1: After reset the run state is stopped, the program counter and upload index are 0, and the queued instruction reads 0.
- R2: A control write (register address 0) with bit 0 set, bit 1 clear and bit 4 clear, made while stopped, enters running and fetches the word at the program counter. A start write made while running or paused is ignored.
- R3: While running, a control write with bit 4 set (bit 0 clear) pauses. While paused, a control write with bit 1 set (bit 0 clear) resumes. A start write from stopped with bit 4 also set enters paused, and still fetches.
- R4: A control write with bits 0 and 1 both set refetches the word at the program counter into the queued-instruction register and leaves the run state unchanged.
- R5: While stopped, a control write with bit 0 clear leaves the state stopped.
- R6: A write to the index register (address 4) sets the upload address. Each write to the data port (address 5) stores the low 24 bits there and increments the index, wrapping from 511 to 0.
- R7: While running, an `advance_i` pulse increments the program counter, wrapping from 511 to 0, and fetches the word at the new count. It has no effect while stopped or paused, or in a cycle with a host write, halt or end.
- R8: `end_i` stops execution and clears the program counter, and it takes precedence over every other request.
- R9: `halt_i` stops execution and leaves the program counter unchanged.
- R10: The status register (address 1) reads 0xE when stopped, 0x03 when running and 0x13 when paused. A control read has bit 0 set when running or paused, and bit 4 set when paused.
- R11: The program counter (address 3) is written from the low 9 bits of write data and reads back zero-extended. The queued instruction (address 2) and the upload index also read back. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 3 | Host register address |
| host_wdata_i | input | 24 | Host write data |
| host_rdata_o | output | 32 | Host read data for `host_addr_i` (combinational) |
| advance_i | input | 1 | Decoder consumed the queued word |
| halt_i | input | 1 | Halt request, program counter kept |
| end_i | input | 1 | End request, program counter cleared |
| fetch_word_o | output | 24 | Queued instruction word |
| run_en_o | output | 1 | High while running |

## Verification
Every state change, program-counter update, index step and fetch takes effect at the first clock edge after the stimulus. The run enable and the queued word are therefore due one cycle later. The bench keeps a behavioural model that it updates on the same rising edge. It compares the registered outputs at every falling edge. Register reads are combinational: the bench sets the address just after a falling edge and samples one time unit later, so each read reflects the state from the preceding rising edge.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    ST_STOP  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } run_state_e;

  localparam logic [ADDR_W-1:0] REG_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] REG_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] REG_OP   = 3'd2;
  localparam logic [ADDR_W-1:0] REG_PC   = 3'd3;
  localparam logic [ADDR_W-1:0] REG_IDX  = 3'd4;
  localparam logic [ADDR_W-1:0] REG_DATA = 3'd5;

  localparam int CB_START  = 0;
  localparam int CB_RESUME = 1;
  localparam int CB_PAUSE  = 4;
endpackage

// File: rtl/useq_code_store.sv
module useq_code_store #(
  parameter int PC_W   = 9,
  parameter int INSN_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PC_W-1:0]   wr_addr_i,
  input  logic [INSN_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [PC_W-1:0]   rd_addr_i,
  output logic [INSN_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << PC_W;

  logic [INSN_W-1:0] mem_q [DEPTH];
  logic [INSN_W-1:0] op_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // queued-instruction register; loads only on a fetch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      op_q <= '0;
    else if (rd_en_i) op_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = op_q;

  // R1
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(op_q));
endmodule

// File: rtl/useq_pc_unit.sv
module useq_pc_unit #(
  parameter int PC_W = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            end_i,
  input  logic            pc_we_i,
  input  logic [PC_W-1:0] pc_wdata_i,
  input  logic            adv_i,
  input  logic            idx_we_i,
  input  logic [PC_W-1:0] idx_wdata_i,
  input  logic            data_we_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] pc_inc_o,
  output logic [PC_W-1:0] idx_o
);
  logic [PC_W-1:0] pc_q, pc_d, idx_q, idx_d;

  assign pc_inc_o = pc_q + 1'b1;

  always_comb begin
    pc_d = pc_q;
    if (end_i)        pc_d = '0;
    else if (pc_we_i) pc_d = pc_wdata_i;
    else if (adv_i)   pc_d = pc_inc_o;
  end

  always_comb begin
    idx_d = idx_q;
    if (idx_we_i)       idx_d = idx_wdata_i;
    else if (data_we_i) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      idx_q <= '0;
    end else begin
      pc_q  <= pc_d;
      idx_q <= idx_d;
    end
  end

  assign pc_o  = pc_q;
  assign idx_o = idx_q;

  // R8
  end_clears_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |=> pc_q == '0);
  // R6
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i && !idx_we_i |=> idx_q == PC_W'($past(idx_q) + 1'b1));
endmodule

// File: rtl/useq_run_fsm.sv
module useq_run_fsm
  import useq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic       start_i,
  input  logic       resume_i,
  input  logic       pause_i,
  input  logic       halt_i,
  input  logic       end_i,
  output run_state_e state_o,
  output logic       load_o
);
  run_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    if (end_i || halt_i) begin
      state_d = ST_STOP;
    end else if (ctrl_we_i) begin
      if (start_i && resume_i) begin
        load_o = 1'b1;                    // refetch only
      end else if (start_i) begin
        if (state_q == ST_STOP) begin
          state_d = pause_i ? ST_PAUSE : ST_RUN;
          load_o  = 1'b1;
        end
      end else if (state_q == ST_RUN && pause_i) begin
        state_d = ST_PAUSE;
      end else if (state_q == ST_PAUSE && resume_i) begin
        state_d = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_STOP;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R8
  stop_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i || halt_i) |=> state_q == ST_STOP);
  // R5
  stopped_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_STOP && ctrl_we_i && !start_i && !end_i && !halt_i |=> state_q == ST_STOP);
  // R4
  reload_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && start_i && resume_i && !end_i && !halt_i |=> $stable(state_q));
  // R2
  start_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_STOP && ctrl_we_i && start_i && !resume_i && !pause_i && !end_i && !halt_i
    |=> state_q == ST_RUN);
endmodule

// File: rtl/useq_run_ctrl.sv
module useq_run_ctrl
  import useq_pkg::*;
#(
  parameter int PC_W   = 9,
  parameter int INSN_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [INSN_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              advance_i,
  input  logic              halt_i,
  input  logic              end_i,
  output logic [INSN_W-1:0] fetch_word_o,
  output logic              run_en_o
);
  logic ctrl_we, pc_we, idx_we, data_we;
  logic adv_eff, load, fetch_en;
  logic [PC_W-1:0] pc, pc_inc, idx, fetch_addr;
  logic [INSN_W-1:0] op;
  run_state_e state;

  assign ctrl_we = host_we_i && host_addr_i == REG_CTRL;
  assign pc_we   = host_we_i && host_addr_i == REG_PC;
  assign idx_we  = host_we_i && host_addr_i == REG_IDX;
  assign data_we = host_we_i && host_addr_i == REG_DATA;

  // host access wins over a same-cycle advance
  assign adv_eff    = advance_i && state == ST_RUN && !end_i && !halt_i && !host_we_i;
  assign fetch_en   = adv_eff || load;
  assign fetch_addr = adv_eff ? pc_inc : pc;

  useq_run_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_we_i(ctrl_we),
    .start_i  (host_wdata_i[CB_START]),
    .resume_i (host_wdata_i[CB_RESUME]),
    .pause_i  (host_wdata_i[CB_PAUSE]),
    .halt_i   (halt_i),
    .end_i    (end_i),
    .state_o  (state),
    .load_o   (load)
  );

  useq_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .end_i      (end_i),
    .pc_we_i    (pc_we),
    .pc_wdata_i (host_wdata_i[PC_W-1:0]),
    .adv_i      (adv_eff),
    .idx_we_i   (idx_we),
    .idx_wdata_i(host_wdata_i[PC_W-1:0]),
    .data_we_i  (data_we),
    .pc_o       (pc),
    .pc_inc_o   (pc_inc),
    .idx_o      (idx)
  );

  useq_code_store #(.PC_W(PC_W), .INSN_W(INSN_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (data_we),
    .wr_addr_i(idx),
    .wr_data_i(host_wdata_i),
    .rd_en_i  (fetch_en),
    .rd_addr_i(fetch_addr),
    .rd_data_o(op)
  );

  always_comb begin
    host_rdata_o = '0;
    case (host_addr_i)
      REG_CTRL: begin
        host_rdata_o[0] = state != ST_STOP;
        host_rdata_o[4] = state == ST_PAUSE;
      end
      REG_STAT: begin
        host_rdata_o[3:0] = (state == ST_STOP) ? 4'hE : 4'h3;
        host_rdata_o[4]   = state == ST_PAUSE;
      end
      REG_OP:  host_rdata_o[INSN_W-1:0] = op;
      REG_PC:  host_rdata_o[PC_W-1:0]   = pc;
      REG_IDX: host_rdata_o[PC_W-1:0]   = idx;
      default: host_rdata_o = '0;
    endcase
  end

  assign fetch_word_o = op;
  assign run_en_o     = state == ST_RUN;

  // R9
  halt_keeps_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && !end_i && !pc_we |=> pc == $past(pc));
  // R7
  idle_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state != ST_RUN && !pc_we && !end_i |=> $stable(pc));
endmodule

// File: tb/useq_run_ctrl_bench.sv
module useq_run_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [23:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        advance = 1'b0, halt = 1'b0, endr = 1'b0;
  logic [23:0] fetch_word;
  logic        run_en;

  int checks = 0, errors = 0;
  bit done = 0;

  // model
  int m_state = 0;  // 0 stop, 1 run, 2 pause
  int m_pc = 0, m_idx = 0, m_op = 0;
  bit m_known = 1;
  int unsigned m_mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_run_ctrl u_useq_run_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .advance_i(advance),
    .halt_i(halt), .end_i(endr), .fetch_word_o(fetch_word), .run_en_o(run_en)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      int ns, fa;
      bit adv, ld, st, rs, ps;
      bit cw;
      cw = host_we && host_addr == 0;
      st = host_wdata[0]; rs = host_wdata[1]; ps = host_wdata[4];
      adv = advance && m_state == 1 && !endr && !halt && !host_we;
      ld = 0; ns = m_state;
      if (endr || halt) ns = 0;
      else if (cw) begin
        if (st && rs) ld = 1;
        else if (st) begin
          if (m_state == 0) begin ns = ps ? 2 : 1; ld = 1; end
        end else if (m_state == 1 && ps) ns = 2;
        else if (m_state == 2 && rs) ns = 1;
      end
      fa = adv ? (m_pc + 1) % 512 : m_pc;
      if (adv || ld) begin
        if (m_mem.exists(fa)) begin m_op = int'(m_mem[fa]); m_known = 1; end
        else m_known = 0;
      end
      if (endr) m_pc = 0;
      else if (host_we && host_addr == 3) m_pc = int'(host_wdata) % 512;
      else if (adv) m_pc = (m_pc + 1) % 512;
      if (host_we && host_addr == 5) begin
        m_mem[m_idx] = host_wdata;
        m_idx = (m_idx + 1) % 512;
      end else if (host_we && host_addr == 4) m_idx = int'(host_wdata) % 512;
      m_state = ns;
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0: return ((m_state != 0) ? 1 : 0) | ((m_state == 2) ? 'h10 : 0);
      1: return (m_state == 0) ? 'hE : (m_state == 2) ? 'h13 : 'h3;
      2: return m_op;
      3: return m_pc;
      4: return m_idx;
      default: return 0;
    endcase
  endfunction

  // per-cycle compare of registered outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (run_en !== (m_state == 1)) begin
        errors++;
        $display("FAIL R3 run_en act=%0b exp=%0b t=%0t", run_en, m_state == 1, $time);
      end
      if (m_known) begin
        checks++;
        if (fetch_word !== m_op[23:0]) begin
          errors++;
          $display("FAIL R7 fetch_word act=%06h exp=%06h t=%0t", fetch_word, m_op[23:0], $time);
        end
      end
    end
  end

  task automatic hw(input int a, input int d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 3'(a); host_wdata = 24'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic pulse(input bit a, input bit h, input bit e);
    @(negedge clk);
    advance = a; halt = h; endr = e;
    @(negedge clk);
    advance = 1'b0; halt = 1'b0; endr = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    int exp;
    @(negedge clk);
    host_addr = 3'(a);
    #1;
    exp = model_read(a);
    checks++;
    if (host_rdata !== 32'(exp)) begin
      errors++;
      $display("FAIL %s addr=%0d act=%08h exp=%08h", tag, a, host_rdata, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1, "R1"); rd(3, "R1"); rd(2, "R1"); rd(4, "R1");
    // R6 upload ten words from 0
    hw(4, 0);
    for (int k = 0; k < 10; k++) hw(5, 'h0A0000 + k * 'h0101);
    rd(4, "R6");
    hw(4, 510); hw(5, 'h5A5A5A); hw(5, 'h3C3C3C);
    rd(4, "R6");                      // wrapped to 0
    rd(6, "R11"); rd(5, "R11");
    // R5 stopped ignores pause/resume-only writes
    hw(0, 'h10); rd(1, "R5");
    hw(0, 'h02); rd(1, "R5");
    // R2 start
    hw(0, 'h01); rd(1, "R10"); rd(0, "R10"); rd(2, "R2");
    hw(0, 'h01); rd(1, "R2");         // start while running ignored
    // R7 advance three times
    pulse(1, 0, 0); pulse(1, 0, 0); pulse(1, 0, 0);
    rd(3, "R7"); rd(2, "R7");
    // R3 pause, advance ignored, resume
    hw(0, 'h10); rd(1, "R3"); rd(0, "R10");
    pulse(1, 0, 0); rd(3, "R7");
    hw(0, 'h02); rd(1, "R3");
    // R7 host write beats advance
    @(negedge clk); host_we = 1'b1; host_addr = 3'd4; host_wdata = 24'd0; advance = 1'b1;
    @(negedge clk); host_we = 1'b0; advance = 1'b0;
    rd(3, "R7");
    // R11 pc write, R4 reload while running
    hw(3, 'hFFF007); rd(3, "R11");
    hw(0, 'h03); rd(2, "R4"); rd(1, "R4");
    // R9 halt keeps pc
    pulse(0, 1, 0); rd(1, "R9"); rd(3, "R9");
    // R4 reload while stopped
    hw(3, 2); hw(0, 'h03); rd(2, "R4"); rd(1, "R4");
    // R8 end clears pc; end with halt
    hw(0, 'h01); pulse(1, 0, 0);
    pulse(0, 1, 1); rd(1, "R8"); rd(3, "R8");
    // R3 start in paused state
    hw(3, 5); hw(0, 'h11); rd(1, "R3"); rd(2, "R3");
    pulse(1, 0, 0); rd(3, "R7");
    hw(0, 'h02); rd(1, "R3");
    pulse(0, 0, 1); rd(3, "R8");
    // R7 wrap 511 -> 0
    hw(3, 511); hw(0, 'h01); rd(2, "R7");
    pulse(1, 0, 0); rd(3, "R7"); rd(2, "R7");
    pulse(0, 0, 1); rd(1, "R8");
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule